// File: doc/BRIEF.md
# Expansion ROM Base Register and Window Decoder

This block is the configuration register that maps a device's expansion ROM into host memory, together with the address decoder behind it. Configuration writes and reads arrive as a dword index, four byte enables and 32 bits of data. Memory reads arrive as a request strobe with a dword address. The block answers the memory read from a small internal ROM image that begins with the bytes 55h and AAh, which is the signature host firmware looks for.

Host firmware discovers the ROM in three steps. First it writes all ones into the base field and reads back a mask, which gives the size and the alignment. Next it programs a base that is aligned to that size. Finally it sets the register's enable bit. The ROM answers only while that enable bit and the memory-space bit of the command register are both set. Parameters set the ROM size (as a power of two), the header kind (general or bridge, which decides which configuration dword the register occupies) and whether a ROM is implemented at all.

Top module: `xrom_bar_decoder`

## Requirements
- R1: With HDR_BRIDGE=0 the register sits at dword index 0Ch (byte offset 30h). With HDR_BRIDGE=1 it sits at dword index 0Eh (byte offset 38h). A write to the other index does not change it, and a read of the other index returns 0.
- R2: After reset the register reads 0, the command dword (index 01h) reads 0, and rom_enabled is 0.
- R3: When FFFF_F800h is written with all byte enables and the register is read back, the result is the size mask ~(2^ROM_SIZE_LOG2 - 1) with bit 0 cleared. For the default 128 KB ROM this is FFFE_0000h. For a 4 KB ROM it is FFFF_F000h.
- R4: Bits ROM_SIZE_LOG2-1 down to 1, which include the reserved bits 10:1, always read 0 and ignore writes. rom_base therefore always holds a multiple of the ROM size.
- R5: A configuration write updates only the writable bits that lie in the enabled byte lanes. cfg_be[k] covers data bits 8k+7 down to 8k.
- R6: Bit 0 of the register is the ROM enable. Bit 1 of the command dword is the memory-space enable, written through lane 0. The output rom_enabled is high exactly when both bits are 1, and no memory read hits while it is low.
- R7: A memory read hits when rom_enabled is high and address bits 31 down to ROM_SIZE_LOG2 equal the programmed base. mem_hit and mem_rdata are valid in the cycle after the request. On a miss, or in a cycle with no request, mem_hit is 0 and mem_rdata is 0.
- R8: ROM byte 0 is 55h and byte 1 is AAh. Byte n, for 2 <= n < 4*IMG_WORDS, is (n mod 256) XOR 3Ch. Byte n sits in lane n mod 4 of the dword. A hit at a window offset at or beyond the image returns 0.
- R9: With ROM_PRESENT=0 the register reads 0 even after the all-ones probe, and no memory read ever hits.
- R10: A configuration read returns its data in cfg_rdata in the cycle after cfg_rd, and cfg_rdata holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_idx | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Configuration byte enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, registered |
| mem_req | input | 1 | Memory read request |
| mem_dw_addr | input | 30 | Memory read address, bits 31:2 |
| mem_hit | output | 1 | Request decoded to the ROM window, registered |
| mem_rdata | output | 32 | ROM read data, registered |
| rom_base | output | 32 | Programmed base address (enable bit removed) |
| rom_enabled | output | 1 | ROM enable and memory-space enable both set |

## Verification
The hardest behaviour to reach from the ports is the set of cases where the two enables disagree. A correct base plus only one of the two enable bits must still miss, and a window offset past the image must hit yet return zero. The stimulus programs a real base first. It then sets and clears the ROM enable and the memory-space bit one at a time, with memory reads in between, and it reads inside the window, beyond the image, and one window above and below. Two extra instances share the buses: one with a bridge header and a 4 KB ROM, and one with no ROM. Together they show that each register ignores the other's dword and that a missing ROM masks the probe to zero.

// File: rtl/xrom_pkg.sv
package xrom_pkg;
  localparam logic [5:0] IDX_CMD    = 6'h01;
  localparam logic [5:0] IDX_XROM_0 = 6'h0C;
  localparam logic [5:0] IDX_XROM_1 = 6'h0E;
  localparam logic [7:0] SIG_LO     = 8'h55;
  localparam logic [7:0] SIG_HI     = 8'hAA;
  localparam logic [7:0] FILL_KEY   = 8'h3C;
  localparam int         CMD_MEM_BIT = 1;
endpackage

// File: rtl/xrom_cmd_reg.sv
module xrom_cmd_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic lane0_en,
  input  logic wbit,
  output logic mem_space
);
  logic mem_space_d;
  logic mem_space_ce;

  always_comb begin
    mem_space_ce = wr_hit & lane0_en;
    mem_space_d  = wbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            mem_space <= 1'b0;
    else if (mem_space_ce) mem_space <= mem_space_d;
  end
endmodule

// File: rtl/xrom_bar_reg.sv
module xrom_bar_reg #(
  parameter int ROM_SIZE_LOG2 = 17,
  parameter bit ROM_PRESENT   = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] bar_q
);
  localparam logic [31:0] SIZE_MASK = ~((32'h1 << ROM_SIZE_LOG2) - 32'h1);
  localparam logic [31:0] WR_MASK   = ROM_PRESENT ? (SIZE_MASK | 32'h1) : 32'h0;

  logic [31:0] lane_mask;
  logic [31:0] bar_d;
  logic        bar_ce;

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign lane_mask[8*k +: 8] = {8{be[k]}};
  end

  always_comb begin
    bar_ce = wr_hit & (|be);
    bar_d  = (bar_q & ~(WR_MASK & lane_mask)) | (wdata & WR_MASK & lane_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bar_q <= 32'h0;
    else if (bar_ce) bar_q <= bar_d;
  end
endmodule

// File: rtl/xrom_image.sv
module xrom_image #(
  parameter int IDX_W     = 15,
  parameter int IMG_WORDS = 8
) (
  input  logic [IDX_W-1:0] idx,
  output logic [31:0]      word
);
  import xrom_pkg::*;

  function automatic logic [7:0] img_byte(input logic [IDX_W-1:0] i, input logic [1:0] lane);
    logic [7:0] n;
    n = {i[5:0], lane};
    if (n == 8'd0 && i == '0)      return SIG_LO;
    else if (n == 8'd1 && i == '0) return SIG_HI;
    else                           return n ^ FILL_KEY;
  endfunction

  always_comb begin
    word = 32'h0;
    if (idx < IDX_W'(IMG_WORDS)) begin
      for (int k = 0; k < 4; k++) word[8*k +: 8] = img_byte(idx, 2'(k));
    end
  end
endmodule

// File: rtl/xrom_decode.sv
module xrom_decode #(
  parameter int ROM_SIZE_LOG2 = 17,
  parameter int IMG_WORDS     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [29:0] dw_addr,
  input  logic [31:0] base,
  input  logic        enabled,
  output logic        hit,
  output logic [31:0] rdata
);
  localparam int IDX_W = ROM_SIZE_LOG2 - 2;
  localparam int TAG_W = 32 - ROM_SIZE_LOG2;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic [31:0]      img_word;
  logic             hit_d;
  logic [31:0]      rdata_d;

  assign idx = dw_addr[IDX_W-1:0];
  assign tag = dw_addr[29:IDX_W];

  xrom_image #(.IDX_W(IDX_W), .IMG_WORDS(IMG_WORDS)) u_image (
    .idx  (idx),
    .word (img_word)
  );

  always_comb begin
    hit_d   = req & enabled & (tag == base[31:ROM_SIZE_LOG2]);
    rdata_d = hit_d ? img_word : 32'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit   <= 1'b0;
      rdata <= 32'h0;
    end else begin
      hit   <= hit_d;
      rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/xrom_bar_decoder.sv
module xrom_bar_decoder #(
  parameter int ROM_SIZE_LOG2 = 17,
  parameter bit HDR_BRIDGE    = 1'b0,
  parameter bit ROM_PRESENT   = 1'b1,
  parameter int IMG_WORDS     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_rd,
  input  logic [5:0]  cfg_idx,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        mem_req,
  input  logic [29:0] mem_dw_addr,
  output logic        mem_hit,
  output logic [31:0] mem_rdata,
  output logic [31:0] rom_base,
  output logic        rom_enabled
);
  import xrom_pkg::*;

  localparam logic [5:0] IDX_XROM = HDR_BRIDGE ? IDX_XROM_1 : IDX_XROM_0;

  logic [1:0]  rst_sync;
  logic        rst_int_n;
  logic [31:0] bar_q;
  logic        mem_space;
  logic        bar_sel;
  logic        cmd_sel;
  logic [31:0] rdata_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign bar_sel = (cfg_idx == IDX_XROM);
  assign cmd_sel = (cfg_idx == IDX_CMD);

  xrom_bar_reg #(.ROM_SIZE_LOG2(ROM_SIZE_LOG2), .ROM_PRESENT(ROM_PRESENT)) u_bar (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_hit (cfg_wr & bar_sel),
    .be     (cfg_be),
    .wdata  (cfg_wdata),
    .bar_q  (bar_q)
  );

  xrom_cmd_reg u_cmd (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_hit    (cfg_wr & cmd_sel),
    .lane0_en  (cfg_be[0]),
    .wbit      (cfg_wdata[CMD_MEM_BIT]),
    .mem_space (mem_space)
  );

  assign rom_base    = {bar_q[31:1], 1'b0};
  assign rom_enabled = bar_q[0] & mem_space;

  xrom_decode #(.ROM_SIZE_LOG2(ROM_SIZE_LOG2), .IMG_WORDS(IMG_WORDS)) u_dec (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .req     (mem_req),
    .dw_addr (mem_dw_addr),
    .base    (rom_base),
    .enabled (rom_enabled),
    .hit     (mem_hit),
    .rdata   (mem_rdata)
  );

  always_comb begin
    rdata_d = 32'h0;
    if (bar_sel)      rdata_d = bar_q;
    else if (cmd_sel) rdata_d[CMD_MEM_BIT] = mem_space;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  cfg_rdata <= 32'h0;
    else if (cfg_rd) cfg_rdata <= rdata_d;
  end
endmodule

// File: rtl/xrom_bar_checker.sv
module xrom_bar_checker #(
  parameter int ROM_SIZE_LOG2 = 17,
  parameter bit ROM_PRESENT   = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic        mem_req,
  input logic [29:0] mem_dw_addr,
  input logic        mem_hit,
  input logic [31:0] mem_rdata,
  input logic [31:0] rom_base,
  input logic        rom_enabled
);
  localparam logic [31:0] LOW_MASK = (32'h1 << ROM_SIZE_LOG2) - 32'h1;
  localparam int IDX_W = ROM_SIZE_LOG2 - 2;

  // R4: the base never carries bits below the size boundary
  p_base_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_base & LOW_MASK) == 32'h0);

  // R6: no hit while the combined enable is low
  p_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !rom_enabled) |=> !mem_hit);

  // R6: the enable only rises as a result of a configuration write
  p_enable_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rom_enabled) |-> $past(cfg_wr));

  // R7: idle cycles produce no hit
  p_idle_nohit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |=> !mem_hit);

  // R7: a miss returns zero data
  p_miss_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_hit |-> mem_rdata == 32'h0);

  // R8: offset zero of a live window returns the signature
  p_signature_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && rom_enabled && mem_dw_addr[IDX_W-1:0] == '0 &&
     mem_dw_addr[29:IDX_W] == rom_base[31:ROM_SIZE_LOG2])
    |=> (mem_hit && mem_rdata[15:0] == 16'hAA55));

  if (!ROM_PRESENT) begin : g_absent
    // R9: an absent ROM never hits
    p_absent_nohit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_hit);
  end
endmodule

bind xrom_bar_decoder xrom_bar_checker #(
  .ROM_SIZE_LOG2 (ROM_SIZE_LOG2),
  .ROM_PRESENT   (ROM_PRESENT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr      (cfg_wr),
  .mem_req     (mem_req),
  .mem_dw_addr (mem_dw_addr),
  .mem_hit     (mem_hit),
  .mem_rdata   (mem_rdata),
  .rom_base    (rom_base),
  .rom_enabled (rom_enabled)
);

// File: tb/xrom_bar_decoder_bench.sv
`timescale 1ns/1ps
module xrom_bar_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [5:0]  cfg_idx = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        mem_req = 1'b0;
  logic [29:0] mem_dw_addr = '0;

  logic [31:0] rd_a, rd_b, rd_c;
  logic        hit_a, hit_b, hit_c;
  logic [31:0] md_a, md_b, md_c;
  logic [31:0] base_a, base_b, base_c;
  logic        en_a, en_b, en_c;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  xrom_bar_decoder u_xrom_bar_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_idx(cfg_idx),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rd_a), .mem_req(mem_req),
    .mem_dw_addr(mem_dw_addr), .mem_hit(hit_a), .mem_rdata(md_a),
    .rom_base(base_a), .rom_enabled(en_a));

  xrom_bar_decoder #(.ROM_SIZE_LOG2(12), .HDR_BRIDGE(1'b1)) u_xrom_bar_decoder_bridge (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_idx(cfg_idx),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rd_b), .mem_req(mem_req),
    .mem_dw_addr(mem_dw_addr), .mem_hit(hit_b), .mem_rdata(md_b),
    .rom_base(base_b), .rom_enabled(en_b));

  xrom_bar_decoder #(.ROM_PRESENT(1'b0)) u_xrom_bar_decoder_absent (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_idx(cfg_idx),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rd_c), .mem_req(mem_req),
    .mem_dw_addr(mem_dw_addr), .mem_hit(hit_c), .mem_rdata(md_c),
    .rom_base(base_c), .rom_enabled(en_c));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // R8 image model, built from the requirement text
  function automatic logic [31:0] img_word(input int dw);
    logic [31:0] w;
    if (dw >= 8) return 32'h0;
    for (int k = 0; k < 4; k++) begin
      int n = 4 * dw + k;
      if (n == 0)      w[8*k +: 8] = 8'h55;
      else if (n == 1) w[8*k +: 8] = 8'hAA;
      else             w[8*k +: 8] = 8'(n) ^ 8'h3C;
    end
    return w;
  endfunction

  task automatic cfg_write(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = idx; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic cfg_read(input logic [5:0] idx);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_idx = idx;
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  task automatic mem_read(input logic [31:0] addr);
    @(negedge clk);
    mem_req = 1'b1; mem_dw_addr = addr[31:2];
    @(negedge clk);
    mem_req = 1'b0;
  endtask

  task automatic t_reset;
    cfg_read(6'h0C);
    chk("R2 bar after reset", rd_a, 32'h0);
    cfg_read(6'h01);
    chk("R2 cmd after reset", rd_a, 32'h0);
    chk("R2 enabled after reset", {31'b0, en_a}, 32'h0);
  endtask

  task automatic t_probe;
    cfg_write(6'h0C, 4'hF, 32'hFFFF_F800);
    cfg_read(6'h0C);
    chk("R3 probe 128K", rd_a, 32'hFFFE_0000);
    chk("R9 absent probe", rd_c, 32'h0);
    chk("R1 bridge ignores 0Ch", rd_b, 32'h0);
    cfg_read(6'h0E);
    chk("R1 general reads 0 at 0Eh", rd_a, 32'h0);
    cfg_write(6'h0E, 4'hF, 32'hFFFF_F800);
    cfg_read(6'h0E);
    chk("R3 probe 4K bridge", rd_b, 32'hFFFF_F000);
    cfg_read(6'h0C);
    chk("R1 general untouched by 0Eh", rd_a, 32'hFFFE_0000);
    chk("R10 read data held", rd_a, 32'hFFFE_0000);
  endtask

  task automatic t_align;
    cfg_write(6'h0C, 4'hF, 32'h1235_67FE);
    cfg_read(6'h0C);
    chk("R4 low bits dropped", rd_a, 32'h1234_0000);
    chk("R4 rom_base aligned", base_a, 32'h1234_0000);
  endtask

  task automatic t_lanes;
    cfg_write(6'h0C, 4'b1000, 32'hABCD_EF01);
    cfg_read(6'h0C);
    chk("R5 top lane only", rd_a, 32'hAB34_0000);
    cfg_write(6'h0C, 4'b0001, 32'hFFFF_FF01);
    cfg_read(6'h0C);
    chk("R5 lane0 sets enable", rd_a, 32'hAB34_0001);
    chk("R6 cmd off keeps disabled", {31'b0, en_a}, 32'h0);
  endtask

  task automatic t_gate_and_hit;
    mem_read(32'hAB34_0000);
    chk("R6 no hit cmd off", {31'b0, hit_a}, 32'h0);
    chk("R7 miss data zero", md_a, 32'h0);
    cfg_write(6'h01, 4'b0001, 32'h0000_0002);
    cfg_read(6'h01);
    chk("R6 cmd readback", rd_a, 32'h0000_0002);
    chk("R6 enabled both set", {31'b0, en_a}, 32'h1);
    mem_read(32'hAB34_0000);
    chk("R7 hit at base", {31'b0, hit_a}, 32'h1);
    chk("R8 signature dword", md_a, img_word(0));
    mem_read(32'hAB34_0004);
    chk("R8 dword 1", md_a, img_word(1));
    mem_read(32'hAB34_001C);
    chk("R8 last image dword", md_a, img_word(7));
    mem_read(32'hAB35_FFFC);
    chk("R8 beyond image hit", {31'b0, hit_a}, 32'h1);
    chk("R8 beyond image zero", md_a, 32'h0);
    mem_read(32'hAB36_0000);
    chk("R7 above window miss", {31'b0, hit_a}, 32'h0);
    mem_read(32'hAB33_FFFC);
    chk("R7 below window miss", {31'b0, hit_a}, 32'h0);
    chk("R9 absent never hits", {31'b0, hit_c}, 32'h0);
    @(negedge clk);
    chk("R7 idle no hit", {31'b0, hit_a}, 32'h0);
    cfg_write(6'h0C, 4'b0001, 32'h0);
    chk("R6 bar enable cleared", {31'b0, en_a}, 32'h0);
    mem_read(32'hAB34_0000);
    chk("R6 no hit bar off", {31'b0, hit_a}, 32'h0);
    cfg_write(6'h0C, 4'b0001, 32'h1);
    cfg_write(6'h01, 4'b0001, 32'h0);
    mem_read(32'hAB34_0000);
    chk("R6 no hit mem space off", {31'b0, hit_a}, 32'h0);
  endtask

  task automatic t_bridge;
    cfg_write(6'h0E, 4'hF, 32'h0000_5001);
    cfg_write(6'h01, 4'b0001, 32'h2);
    mem_read(32'h0000_5004);
    chk("R7 bridge hit", {31'b0, hit_b}, 32'h1);
    chk("R8 bridge data", md_b, img_word(1));
    chk("R7 general misses", {31'b0, hit_a}, 32'h0);
    chk("R9 absent base zero", base_c, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_probe();
    t_align();
    t_lanes();
    t_gate_and_hit();
    t_bridge();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule